// File: doc/BRIEF.md
# Masked Multichannel ADC Scan Sequencer

This block drives a multiplexed acquisition front end. A 26-bit enable mask is held in two 16-bit registers. The first register covers channels 1 to 16 and the low ten bits of the second cover channels 17 to 26. Channel 25 is tied to analog ground and channel 26 to the reference bus, and both are scanned like any other channel. Each trigger from the selected source starts one pass over the enabled channels, lowest number first.

For each channel the sequencer sets the multiplexer select and waits a settling interval counted in system clock cycles. It then pulses a convert start to an external converter. When the converter reports done, the sample and its channel number are offered to the write port of an external FIFO.

The trigger can come from a free-running rate divider, a backplane line, a front-panel line or a software command. A small write/read register bus sets the mask, the settle length, the trigger source and the rate period. The same bus exposes the busy bit and two sticky error flags. The floor parameter `MIN_SETTLE` defaults to 5100 cycles, which is 51 µs at 100 MHz.

Top module: `adc_scan_sequencer`

## Requirements
- R1: Register 0 holds the enable bits for channels 1–16 (bit n = channel n+1), and register 1 bits 0–9 hold channels 17–26; both read back as written. Bits 15:10 of register 1 always read 0 and enable nothing.
- R2: Each accepted trigger yields exactly one conversion per enabled channel, in ascending channel order, with channels 25 and 26 included when enabled.
- R3: Each FIFO word has the channel number (1–26) in bits 20:16 and, in bits 15:0, the converter data present in the cycle `adc_done` is high.
- R4: `adc_start` is a single-cycle pulse. It rises exactly max(register 2, `MIN_SETTLE`) cycles after `mux_sel` switches to the channel being converted.
- R5: `mux_sel` shows the channel number of the channel under conversion. It changes only when the settle counter is loaded, which happens at scan start or on a done that has a further channel to convert.
- R6: Register 3 bits 1:0 pick the trigger source: 0 = rate divider, 1 = rising edge of `trig_backplane`, 2 = rising edge of `trig_panel`, 3 = software (write with bit 0 set to register 4). Sources that are not selected have no effect.
- R7: With source 0 and a nonzero period P in register 5, a trigger occurs once every P cycles. With P = 0, no trigger occurs.
- R8: A trigger that arrives while a scan is running is dropped and sets status bit 1 (register 6). Writing 1 to that bit clears it.
- R9: A trigger with an all-zero mask starts no conversion, and `busy` stays low.
- R10: While `fifo_full` is high no word is written. A conversion that completes then sets status bit 2, which is cleared by writing 1, and the scan continues to its end.
- R11: After reset all registers read 0, and `mux_sel`, `adc_start`, `fifo_wr` and `busy` are 0.
- R12: The mask is captured when a scan starts. Mask writes during a scan apply from the next scan on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| trig_backplane | input | 1 | Backplane trigger line, synchronous |
| trig_panel | input | 1 | Front-panel trigger line, synchronous |
| mux_sel | output | 5 | Multiplexer channel number, 1–26 (0 after reset) |
| adc_start | output | 1 | Convert start pulse |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | DATA_W (16) | Conversion result |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_wdata | output | DATA_W+5 (21) | Channel number and sample |
| fifo_full | input | 1 | FIFO cannot accept a word |
| busy | output | 1 | A scan is in progress |

## Verification
Several properties are checked on every cycle by assertions: the convert pulse lasts one cycle and lands exactly the settle length after the load that switched the multiplexer; the select holds between loads; nothing is written while the FIFO is full; every written word belongs to an enabled channel of the captured mask; an empty mask leaves the engine idle; the error flags set on their events and clear on write-one; and a rate divider with a zero period stays quiet. Other behaviour needs whole scenarios, and only the bench scenarios can show it: complete ascending channel lists for random masks, exactly one scan per trigger under overrun, the spacing of rate triggers, masking of unselected sources, the snapshot of the mask, and the register read-back.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int NUM_CH = 26;
  localparam int CH_W   = 5;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 3;
  localparam int LO_CH  = 16;
  localparam int HI_CH  = NUM_CH - LO_CH;
  localparam int SRC_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_LO = 3'd0,
    A_MASK_HI = 3'd1,
    A_SETTLE  = 3'd2,
    A_TRIG    = 3'd3,
    A_CMD     = 3'd4,
    A_RATE    = 3'd5,
    A_STATUS  = 3'd6
  } reg_addr_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_RATE      = 2'd0,
    SRC_BACKPLANE = 2'd1,
    SRC_PANEL     = 2'd2,
    SRC_SOFT      = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    ENG_IDLE    = 2'd0,
    ENG_SETTLE  = 2'd1,
    ENG_CONVERT = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic            found;
    logic [CH_W-1:0] idx;
  } ch_pick_t;

  // Lowest enabled channel index at or above 'from' (0-based).
  function automatic ch_pick_t pick_channel(input logic [NUM_CH-1:0] m,
                                            input logic [CH_W-1:0]   from);
    ch_pick_t r;
    r = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (m[c] && (c >= int'(from))) begin
        r.found = 1'b1;
        r.idx   = CH_W'(c);
      end
    end
    return r;
  endfunction

  // Requested settle length, raised to the floor if shorter.
  function automatic logic [BUS_W-1:0] settle_floor(input logic [BUS_W-1:0] req,
                                                    input logic [BUS_W-1:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  function automatic logic [NUM_CH-1:0] join_mask(input logic [BUS_W-1:0] lo,
                                                  input logic [HI_CH-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/scan_seq_regs.sv
module scan_seq_regs
  import scan_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] mask,
  output logic [BUS_W-1:0]  settle_val,
  output trig_src_e         trig_src,
  output logic [BUS_W-1:0]  rate_period,
  output logic              sw_fire,
  input  logic              busy,
  input  logic              evt_overrun,
  input  logic              evt_overflow
);

  logic [BUS_W-1:0] mask_lo_q;
  logic [HI_CH-1:0] mask_hi_q;
  logic [BUS_W-1:0] settle_q;
  logic [BUS_W-1:0] rate_q;
  trig_src_e        src_q;
  logic             ovr_q;
  logic             ofl_q;
  logic             status_wr;

  assign status_wr   = bus_wr && (bus_addr == A_STATUS);
  assign sw_fire     = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];
  assign mask        = join_mask(mask_lo_q, mask_hi_q);
  assign settle_val  = settle_q;
  assign trig_src    = src_q;
  assign rate_period = rate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo_q <= '0;
      mask_hi_q <= '0;
      settle_q  <= '0;
      rate_q    <= '0;
      src_q     <= SRC_RATE;
      ovr_q     <= 1'b0;
      ofl_q     <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_MASK_LO: mask_lo_q <= bus_wdata;
          A_MASK_HI: mask_hi_q <= bus_wdata[HI_CH-1:0];
          A_SETTLE:  settle_q  <= bus_wdata;
          A_TRIG:    src_q     <= trig_src_e'(bus_wdata[SRC_W-1:0]);
          A_RATE:    rate_q    <= bus_wdata;
          default: ;
        endcase
      end
      ovr_q <= evt_overrun  | (ovr_q & ~(status_wr & bus_wdata[1]));
      ofl_q <= evt_overflow | (ofl_q & ~(status_wr & bus_wdata[2]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK_LO: bus_rdata = mask_lo_q;
      A_MASK_HI: bus_rdata = {{(BUS_W-HI_CH){1'b0}}, mask_hi_q};
      A_SETTLE:  bus_rdata = settle_q;
      A_TRIG:    bus_rdata = {{(BUS_W-SRC_W){1'b0}}, src_q};
      A_RATE:    bus_rdata = rate_q;
      A_STATUS:  bus_rdata = {{(BUS_W-3){1'b0}}, ofl_q, ovr_q, busy};
      default:   bus_rdata = '0;
    endcase
  end

  a_r1_hi_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MASK_HI) |-> (bus_rdata[BUS_W-1:HI_CH] == '0));

  a_r8_overrun_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |=> ovr_q);

  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && bus_wdata[1] && !evt_overrun) |=> !ovr_q);

  a_r10_overflow_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> ofl_q);

  a_r10_overflow_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && bus_wdata[2] && !evt_overflow) |=> !ofl_q);

endmodule

// File: rtl/scan_seq_trigger.sv
module scan_seq_trigger
  import scan_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  trig_src_e        src,
  input  logic [BUS_W-1:0] rate_period,
  input  logic             ext_backplane,
  input  logic             ext_panel,
  input  logic             sw_fire,
  output logic             trig_pulse
);

  logic             bp_q;
  logic             fp_q;
  logic [BUS_W-1:0] rate_cnt;
  logic             rate_run;
  logic             rate_hit;
  logic             fire;

  assign rate_run = (src == SRC_RATE) && (rate_period != '0);
  assign rate_hit = rate_run && (rate_cnt == rate_period - BUS_W'(1));

  always_comb begin
    case (src)
      SRC_RATE:      fire = rate_hit;
      SRC_BACKPLANE: fire = ext_backplane & ~bp_q;
      SRC_PANEL:     fire = ext_panel & ~fp_q;
      SRC_SOFT:      fire = sw_fire;
      default:       fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_q       <= 1'b0;
      fp_q       <= 1'b0;
      rate_cnt   <= '0;
      trig_pulse <= 1'b0;
    end else begin
      bp_q       <= ext_backplane;
      fp_q       <= ext_panel;
      trig_pulse <= fire;
      if (!rate_run || rate_hit) rate_cnt <= '0;
      else                       rate_cnt <= rate_cnt + BUS_W'(1);
    end
  end

  a_r7_rate_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_RATE) && (rate_period == '0)) |=> !trig_pulse);

  a_r6_soft_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_SOFT) && !sw_fire) |=> !trig_pulse);

endmodule

// File: rtl/scan_seq_engine.sv
module scan_seq_engine
  import scan_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MIN_SETTLE = 5100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_pulse,
  input  logic [NUM_CH-1:0]      mask,
  input  logic [BUS_W-1:0]       settle_val,
  output logic [CH_W-1:0]        mux_sel,
  output logic                   adc_start,
  input  logic                   adc_done,
  input  logic [DATA_W-1:0]      adc_data,
  output logic                   fifo_wr,
  output logic [DATA_W+CH_W-1:0] fifo_wdata,
  input  logic                   fifo_full,
  output logic                   busy,
  output logic                   evt_overrun,
  output logic                   evt_overflow
);

  localparam logic [BUS_W-1:0] FLOOR = BUS_W'(MIN_SETTLE);

  eng_state_e        state_q;
  logic [NUM_CH-1:0] snap_q;
  logic [CH_W-1:0]   cur_q;
  logic [BUS_W-1:0]  cnt_q;

  ch_pick_t          first_pick;
  ch_pick_t          next_pick;
  logic [BUS_W-1:0]  settle_len;
  logic              accept;
  logic              conv_done;
  logic              advance;
  logic              load_evt;
  logic [CH_W-1:0]   load_idx;

  always_comb begin
    first_pick = pick_channel(mask, '0);
    next_pick  = pick_channel(snap_q, cur_q + CH_W'(1));
    settle_len = settle_floor(settle_val, FLOOR);
    accept     = (state_q == ENG_IDLE) && trig_pulse && first_pick.found;
    conv_done  = (state_q == ENG_CONVERT) && adc_done;
    advance    = conv_done && next_pick.found;
    load_evt   = accept || advance;
    load_idx   = accept ? first_pick.idx : next_pick.idx;
  end

  assign busy         = (state_q != ENG_IDLE);
  assign evt_overrun  = trig_pulse && (state_q != ENG_IDLE);
  assign fifo_wr      = conv_done && !fifo_full;
  assign evt_overflow = conv_done && fifo_full;
  assign fifo_wdata   = {cur_q + CH_W'(1), adc_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      snap_q    <= '0;
      cur_q     <= '0;
      cnt_q     <= '0;
      mux_sel   <= '0;
      adc_start <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      if (accept) snap_q <= mask;
      if (load_evt) begin
        cur_q   <= load_idx;
        mux_sel <= load_idx + CH_W'(1);
        cnt_q   <= settle_len - BUS_W'(1);
        state_q <= ENG_SETTLE;
      end else begin
        case (state_q)
          ENG_IDLE: ;
          ENG_SETTLE: begin
            if (cnt_q == '0) begin
              state_q   <= ENG_CONVERT;
              adc_start <= 1'b1;
            end else begin
              cnt_q <= cnt_q - BUS_W'(1);
            end
          end
          ENG_CONVERT: if (adc_done) state_q <= ENG_IDLE;
          default: state_q <= ENG_IDLE;
        endcase
      end
    end
  end

  // Window counter for the settle-length property.
  logic [BUS_W:0]   chk_since;
  logic [BUS_W-1:0] chk_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_since <= '0;
      chk_len   <= '0;
    end else if (load_evt) begin
      chk_since <= '0;
      chk_len   <= settle_len;
    end else if (chk_since != '1) begin
      chk_since <= chk_since + (BUS_W+1)'(1);
    end
  end

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r4_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (chk_since == {1'b0, chk_len}));

  a_r5_mux_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(mux_sel));

  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  a_r2_word_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> snap_q[cur_q]);

  a_r9_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ENG_IDLE) && trig_pulse && (mask == '0)) |=> (state_q == ENG_IDLE));

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MIN_SETTLE = 5100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [15:0]            bus_wdata,
  output logic [15:0]            bus_rdata,
  input  logic                   trig_backplane,
  input  logic                   trig_panel,
  output logic [4:0]             mux_sel,
  output logic                   adc_start,
  input  logic                   adc_done,
  input  logic [DATA_W-1:0]      adc_data,
  output logic                   fifo_wr,
  output logic [DATA_W+4:0]      fifo_wdata,
  input  logic                   fifo_full,
  output logic                   busy
);

  logic [NUM_CH-1:0] mask;
  logic [BUS_W-1:0]  settle_val;
  logic [BUS_W-1:0]  rate_period;
  trig_src_e         trig_src;
  logic              sw_fire;
  logic              trig_pulse;
  logic              evt_overrun;
  logic              evt_overflow;

  scan_seq_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .mask         (mask),
    .settle_val   (settle_val),
    .trig_src     (trig_src),
    .rate_period  (rate_period),
    .sw_fire      (sw_fire),
    .busy         (busy),
    .evt_overrun  (evt_overrun),
    .evt_overflow (evt_overflow)
  );

  scan_seq_trigger u_trig (
    .clk           (clk),
    .rst_n         (rst_n),
    .src           (trig_src),
    .rate_period   (rate_period),
    .ext_backplane (trig_backplane),
    .ext_panel     (trig_panel),
    .sw_fire       (sw_fire),
    .trig_pulse    (trig_pulse)
  );

  scan_seq_engine #(
    .DATA_W     (DATA_W),
    .MIN_SETTLE (MIN_SETTLE)
  ) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_pulse   (trig_pulse),
    .mask         (mask),
    .settle_val   (settle_val),
    .mux_sel      (mux_sel),
    .adc_start    (adc_start),
    .adc_done     (adc_done),
    .adc_data     (adc_data),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata),
    .fifo_full    (fifo_full),
    .busy         (busy),
    .evt_overrun  (evt_overrun),
    .evt_overflow (evt_overflow)
  );

endmodule

// File: tb/tb_adc_scan_sequencer.sv
module tb_adc_scan_sequencer;

  localparam int MIN_S = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        trig_backplane = 1'b0;
  logic        trig_panel = 1'b0;
  logic [4:0]  mux_sel;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic        fifo_wr;
  logic [20:0] fifo_wdata;
  logic        fifo_full = 1'b0;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  int starts_total = 0;
  int words_total  = 0;
  int got_ch[$];
  int mux_q[$];
  int settle_meas[$];

  always #5 clk = ~clk;

  adc_scan_sequencer #(.DATA_W(16), .MIN_SETTLE(MIN_S)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_backplane(trig_backplane), .trig_panel(trig_panel),
    .mux_sel(mux_sel), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_full(fifo_full), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_settle(input int req);
    return (req < MIN_S) ? MIN_S : req;
  endfunction

  // Converter model and output monitor, sampled 2 ns after each falling edge.
  initial begin
    bit       pend;
    int       pend_wait;
    int       idx;
    int       sw_idx;
    bit       sw_valid;
    logic [4:0] prev_mux;
    pend = 0; pend_wait = 0; idx = 0; sw_idx = 0; sw_valid = 0; prev_mux = '0;
    forever begin
      @(negedge clk);
      if (pend && pend_wait == 0) begin
        adc_done = 1'b1;
        adc_data = 16'($urandom);
        pend = 0;
      end else begin
        adc_done = 1'b0;
        if (pend) pend_wait--;
      end
      #2;
      idx++;
      if (rst_n) begin
        if (mux_sel != prev_mux) begin
          sw_idx = idx;
          sw_valid = 1;
        end
        prev_mux = mux_sel;
        if (adc_start) begin
          starts_total++;
          mux_q.push_back(int'(mux_sel));
          if (sw_valid) settle_meas.push_back(idx - sw_idx);
          sw_valid = 0;
          pend = 1;
          pend_wait = $urandom_range(0, 3);
        end
        if (adc_done && fifo_full)
          chk(!fifo_wr, "R10", "write while full", int'(fifo_wr), 0);
        if (fifo_wr) begin
          words_total++;
          got_ch.push_back(int'(fifo_wdata[20:16]));
          chk(fifo_wdata[15:0] == adc_data, "R3", "word data field",
              int'(fifo_wdata[15:0]), int'(adc_data));
        end
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_mask(input logic [25:0] m);
    bus_write(3'd0, m[15:0]);
    bus_write(3'd1, {6'b0, m[25:16]});
  endtask

  task automatic fire(input int src);
    case (src)
      1: begin @(negedge clk); trig_backplane = 1'b1; @(negedge clk); trig_backplane = 1'b0; end
      2: begin @(negedge clk); trig_panel = 1'b1; @(negedge clk); trig_panel = 1'b0; end
      default: bus_write(3'd4, 16'h0001);
    endcase
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    repeat (4) @(negedge clk);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_logs();
    got_ch.delete();
    mux_q.delete();
    settle_meas.delete();
  endtask

  // Expected channel list: ascending enabled channels, repeated once per scan.
  task automatic check_scan(input logic [25:0] m, input int scans,
                            input bit words, input string req);
    int exp[$];
    for (int s = 0; s < scans; s++)
      for (int c = 0; c < 26; c++)
        if (m[c]) exp.push_back(c + 1);
    chk(mux_q.size() == exp.size(), req, "conversion count", mux_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < mux_q.size(); i++)
      chk(mux_q[i] == exp[i], "R5", "mux at start", mux_q[i], exp[i]);
    if (words) begin
      chk(got_ch.size() == exp.size(), req, "word count", got_ch.size(), exp.size());
      for (int i = 0; i < exp.size() && i < got_ch.size(); i++)
        chk(got_ch[i] == exp[i], "R2", "word channel", got_ch[i], exp[i]);
    end
  endtask

  task automatic check_settle(input int req_len);
    foreach (settle_meas[i])
      chk(settle_meas[i] == eff_settle(req_len), "R4", "settle cycles",
          settle_meas[i], eff_settle(req_len));
  endtask

  initial begin
    #1_500_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [25:0] m;
    int st;
    int src;
    int s0;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int a = 0; a < 7; a++) begin
      bus_read(3'(a), rv);
      chk(rv == 16'h0, "R11", "register after reset", int'(rv), 0);
    end
    chk(mux_sel == 5'd0 && !adc_start && !fifo_wr && !busy, "R11", "outputs after reset",
        int'({mux_sel, adc_start, fifo_wr, busy}), 0);

    // R1: read-back and reserved bits
    bus_write(3'd0, 16'hA5C3);
    bus_read(3'd0, rv);
    chk(rv == 16'hA5C3, "R1", "mask low read-back", int'(rv), 16'hA5C3);
    bus_write(3'd1, 16'hFFFF);
    bus_read(3'd1, rv);
    chk(rv == 16'h03FF, "R1", "mask high read-back", int'(rv), 16'h03FF);

    // R2: internal channels alone
    bus_write(3'd2, 16'd0);
    bus_write(3'd3, 16'd3);
    set_mask(26'h3000000);
    clear_logs();
    fire(3);
    wait_idle();
    check_scan(26'h3000000, 1, 1, "R2");

    // R1 + R2: all bits of register 1 set; reserved bits enable nothing
    bus_write(3'd1, 16'hFFFF);
    bus_write(3'd0, 16'h0000);
    clear_logs();
    fire(3);
    wait_idle();
    check_scan(26'h3FF0000, 1, 1, "R1");

    // Random scans across sources and settle lengths
    for (int it = 0; it < 10; it++) begin
      m = 26'($urandom);
      if (m == '0) m = 26'h1;
      st = $urandom_range(0, 12);
      src = $urandom_range(1, 3);
      bus_write(3'd2, 16'(st));
      bus_write(3'd3, 16'(src));
      set_mask(m);
      clear_logs();
      fire(src);
      wait_idle();
      check_scan(m, 1, 1, "R2");
      check_settle(st);
    end

    // R4: settle shorter than the floor is raised to it
    bus_write(3'd2, 16'd2);
    bus_write(3'd3, 16'd3);
    set_mask(26'h0000115);
    clear_logs();
    fire(3);
    wait_idle();
    chk(settle_meas.size() > 0, "R4", "settle samples", settle_meas.size(), 1);
    check_settle(2);

    // R8: trigger during a scan is dropped and flagged
    bus_write(3'd2, 16'd12);
    set_mask(26'h3FFFFFF);
    clear_logs();
    fire(3);
    repeat (20) @(negedge clk);
    fire(3);
    wait_idle();
    check_scan(26'h3FFFFFF, 1, 1, "R8");
    bus_read(3'd6, rv);
    chk(rv[1] == 1'b1, "R8", "overrun flag set", int'(rv[1]), 1);
    bus_write(3'd6, 16'h0002);
    bus_read(3'd6, rv);
    chk(rv[1] == 1'b0, "R8", "overrun flag cleared", int'(rv[1]), 0);

    // R10: full FIFO drops words, scan continues, flag set then cleared
    set_mask(26'h000001C);
    clear_logs();
    s0 = words_total;
    fifo_full = 1'b1;
    fire(3);
    wait_idle();
    fifo_full = 1'b0;
    check_scan(26'h000001C, 1, 0, "R10");
    chk(words_total == s0, "R10", "words written while full", words_total - s0, 0);
    bus_read(3'd6, rv);
    chk(rv[2] == 1'b1, "R10", "overflow flag set", int'(rv[2]), 1);
    bus_write(3'd6, 16'h0004);
    bus_read(3'd6, rv);
    chk(rv[2] == 1'b0, "R10", "overflow flag cleared", int'(rv[2]), 0);

    // R12: mask written mid-scan applies to the next scan
    set_mask(26'h00000FF);
    clear_logs();
    fire(3);
    repeat (10) @(negedge clk);
    set_mask(26'h0180000);
    wait_idle();
    check_scan(26'h00000FF, 1, 1, "R12");
    clear_logs();
    fire(3);
    wait_idle();
    check_scan(26'h0180000, 1, 1, "R12");

    // R6: unselected sources ignored, selected one works
    bus_write(3'd3, 16'd1);
    s0 = starts_total;
    fire(2);
    fire(3);
    repeat (40) @(negedge clk);
    chk(starts_total == s0, "R6", "starts from unselected sources", starts_total - s0, 0);
    chk(!busy, "R6", "busy after unselected triggers", int'(busy), 0);
    clear_logs();
    fire(1);
    wait_idle();
    check_scan(26'h0180000, 1, 1, "R6");

    // R9: empty mask
    set_mask(26'h0);
    bus_write(3'd3, 16'd3);
    s0 = starts_total;
    fire(3);
    repeat (3) @(negedge clk);
    chk(!busy, "R9", "busy with empty mask", int'(busy), 0);
    repeat (40) @(negedge clk);
    chk(starts_total == s0, "R9", "starts with empty mask", starts_total - s0, 0);

    // R7: rate divider
    bus_write(3'd2, 16'd0);
    set_mask(26'h0000042);
    bus_write(3'd5, 16'd150);
    clear_logs();
    bus_write(3'd3, 16'd0);
    repeat (525) @(negedge clk);
    bus_write(3'd5, 16'd0);
    repeat (400) @(negedge clk);
    check_scan(26'h0000042, 3, 1, "R7");
    bus_write(3'd3, 16'd3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule